// File: doc/BRIEF.md
# PIO Ready-Stall Watchdog

This block sits beside a programmed-I/O register port. It keeps the host from hanging when an attached device drops its ready line during a register access and never raises it again. While an access is in progress and ready is low, the block counts clock cycles. When the stall reaches a set number of cycles, it does four things. It ends the access with a one-cycle force-complete pulse. It marks the data of that access as invalid. It latches a sticky timeout status bit. It can also raise an interrupt request.

Software controls the block through a 32-bit control/status word. The word holds the watchdog enable, the interrupt enable, the write-one-to-clear timeout status and a read-only copy of the device interrupt line. When interrupts are off, software can poll the timeout bit and the device-interrupt bit. Once reset is released, the watchdog stays off until software sets its enable bit.

Top module: `pio_stall_wdt`

## Requirements
- R1: With the enable bit (bit 13) set, `acc_busy_i` high and `dev_rdy_i` low, the block counts sampled clock edges. If the stall lasts `TIMEOUT` consecutive edges, `force_done_o` is high during the cycle that follows the `TIMEOUT`-th stalled edge.
- R2: The count returns to zero on any edge where `dev_rdy_i` is high or `acc_busy_i` is low. Stalls shorter than `TIMEOUT` edges never produce a pulse, however often they repeat.
- R3: `force_done_o` is high for exactly one cycle. While the same stall continues, the count holds at the threshold and no second pulse follows.
- R4: `data_bad_o` rises together with the force-complete pulse. It stays high until the first edge that samples `acc_busy_i` low.
- R5: The timeout status (bit 12) is set by a timeout and cleared by writing 1 to bit 12. Writing 0 to bit 12 leaves it unchanged. A timeout on the same edge as a clearing write leaves the bit set.
- R6: Bit 13 is a read/write watchdog enable, and all status bits read 0 after reset. While bit 13 is 0, no stall is counted and no pulse is produced.
- R7: Bit 14 is a read/write interrupt enable. `irq_o` equals bit 12 AND bit 14 of the word as currently readable. It stays high until software clears the status or the enable.
- R8: Bit 11 reads `dev_irq_i` as registered one clock earlier. Every bit other than 11 to 14 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_busy_i | input | 1 | A register access is in progress |
| dev_rdy_i | input | 1 | Device ready line (high = ready) |
| dev_irq_i | input | 1 | Device interrupt line |
| csr_we_i | input | 1 | Write strobe for the control/status word |
| csr_wdata_i | input | 32 | Write data for the control/status word |
| csr_rdata_o | output | 32 | Current control/status word |
| force_done_o | output | 1 | One-cycle pulse that ends the stalled access |
| data_bad_o | output | 1 | Data of the current access is invalid |
| irq_o | output | 1 | Watchdog interrupt request |

## Verification
The bench builds the block with `TIMEOUT` set to 16 rather than the default 1000. At that value, random stall lengths fall on both sides of the threshold within a few dozen cycles. This exercises the exact firing edge, near-miss stalls of `TIMEOUT`-1 edges and repeated timeouts during one run. Because the threshold is small, the bench can also place a clearing write on the exact edge where a timeout fires, and it can turn the enable off in the middle of a stall.

// File: rtl/pio_wdt_pkg.sv
package pio_wdt_pkg;
  localparam int CSR_W    = 32;
  localparam int BIT_DIRQ = 11;
  localparam int BIT_TOUT = 12;
  localparam int BIT_EN   = 13;
  localparam int BIT_IE   = 14;
endpackage

// File: rtl/wdt_stall_counter.sv
module wdt_stall_counter #(
  parameter int TIMEOUT = 1000,
  localparam int CNT_W  = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic busy_i,
  input  logic rdy_i,
  output logic hit_o,
  output logic force_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             stalled;

  assign stalled = en_i && busy_i && !rdy_i;
  assign hit_o   = stalled && (cnt_q == CNT_W'(TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      force_o <= 1'b0;
    end else begin
      force_o <= hit_o;
      if (!stalled)
        cnt_q <= '0;
      else if (cnt_q != CNT_W'(TIMEOUT))
        cnt_q <= cnt_q + 1'b1;
    end
  end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(TIMEOUT));
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
    force_o |=> !force_o);
  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !force_o);
  p_ready_clears_r2: assert property (@(posedge clk) disable iff (rst)
    rdy_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_csr.sv
module wdt_csr
  import pio_wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_i,
  input  logic             we_i,
  input  logic [CSR_W-1:0] wdata_i,
  input  logic             dev_irq_i,
  output logic [CSR_W-1:0] rdata_o,
  output logic             en_o,
  output logic             irq_o
);
  logic sts_q, ie_q, dirq_q;
  logic sts_n, ie_n, clr;
  logic unused_wbits;

  assign unused_wbits = ^{wdata_i[CSR_W-1:BIT_IE+1], wdata_i[BIT_TOUT-1:0]};
  assign clr   = we_i && wdata_i[BIT_TOUT];
  assign sts_n = hit_i || (sts_q && !clr);
  assign ie_n  = we_i ? wdata_i[BIT_IE] : ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q  <= 1'b0;
      ie_q   <= 1'b0;
      en_o   <= 1'b0;
      dirq_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      sts_q  <= sts_n;
      ie_q   <= ie_n;
      dirq_q <= dev_irq_i;
      irq_o  <= sts_n && ie_n;
      if (we_i) en_o <= wdata_i[BIT_EN];
    end
  end

  always_comb begin
    rdata_o           = '0;
    rdata_o[BIT_DIRQ] = dirq_q;
    rdata_o[BIT_TOUT] = sts_q;
    rdata_o[BIT_EN]   = en_o;
    rdata_o[BIT_IE]   = ie_q;
  end

  p_w0_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (sts_q && !(we_i && wdata_i[BIT_TOUT])) |=> sts_q);
  p_hit_wins_r5: assert property (@(posedge clk) disable iff (rst)
    hit_i |=> sts_q);
  p_irq_drop_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_o) |-> (!sts_q || !ie_q));
endmodule

// File: rtl/pio_stall_wdt.sv
module pio_stall_wdt
  import pio_wdt_pkg::*;
#(
  parameter int TIMEOUT = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_busy_i,
  input  logic             dev_rdy_i,
  input  logic             dev_irq_i,
  input  logic             csr_we_i,
  input  logic [CSR_W-1:0] csr_wdata_i,
  output logic [CSR_W-1:0] csr_rdata_o,
  output logic             force_done_o,
  output logic             data_bad_o,
  output logic             irq_o
);
  logic wd_en, hit;

  wdt_stall_counter #(.TIMEOUT(TIMEOUT)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .en_i    (wd_en),
    .busy_i  (acc_busy_i),
    .rdy_i   (dev_rdy_i),
    .hit_o   (hit),
    .force_o (force_done_o)
  );

  wdt_csr u_csr (
    .clk       (clk),
    .rst       (rst),
    .hit_i     (hit),
    .we_i      (csr_we_i),
    .wdata_i   (csr_wdata_i),
    .dev_irq_i (dev_irq_i),
    .rdata_o   (csr_rdata_o),
    .en_o      (wd_en),
    .irq_o     (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) data_bad_o <= 1'b0;
    else     data_bad_o <= acc_busy_i && (data_bad_o || hit);
  end

  p_bad_on_force_r4: assert property (@(posedge clk) disable iff (rst)
    force_done_o |-> data_bad_o);
  p_sts_on_force_r5: assert property (@(posedge clk) disable iff (rst)
    force_done_o |-> csr_rdata_o[BIT_TOUT]);
  p_bad_ends_r4: assert property (@(posedge clk) disable iff (rst)
    !acc_busy_i |=> !data_bad_o);
endmodule

// File: tb/pio_stall_wdt_bench.sv
module pio_stall_wdt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int T = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic busy = 0, rdy = 1, dirq = 0, we = 0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic force_done, bad, irq;

  int checks = 0, fails = 0, pulses = 0, first_pulse = -1, cyc = 0;
  bit done = 0;

  // reference state
  int m_cnt = 0;
  bit m_force = 0, m_bad = 0, m_sts = 0, m_en = 0, m_ie = 0, m_irq = 0, m_dirq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_stall_wdt #(.TIMEOUT(T)) u_pio_stall_wdt (
    .clk(clk), .rst(rst), .acc_busy_i(busy), .dev_rdy_i(rdy), .dev_irq_i(dirq),
    .csr_we_i(we), .csr_wdata_i(wd), .csr_rdata_o(rdata),
    .force_done_o(force_done), .data_bad_o(bad), .irq_o(irq));

  function automatic logic [31:0] exp_rdata();
    logic [31:0] v = '0;
    v[11] = m_dirq; v[12] = m_sts; v[13] = m_en; v[14] = m_ie;
    return v;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic model_edge(input bit b, input bit r, input bit w, input logic [31:0] d, input bit di);
    bit hit, n_sts, n_ie;
    hit   = m_en && b && !r && (m_cnt == T-1);
    n_sts = hit || (m_sts && !(w && d[12]));
    n_ie  = w ? d[14] : m_ie;
    if (!m_en || !b || r) m_cnt = 0;
    else if (m_cnt != T)  m_cnt = m_cnt + 1;
    m_bad = b && (m_bad || hit);
    m_force = hit;
    m_sts = n_sts;
    m_ie = n_ie;
    if (w) m_en = d[13];
    m_irq = n_sts && n_ie;
    m_dirq = di;
  endtask

  task automatic compare_all();
    chk("R1", "force_done", 32'(force_done), 32'(m_force));
    chk("R4", "data_bad", 32'(bad), 32'(m_bad));
    chk("R7", "irq", 32'(irq), 32'(m_irq));
    chk("R5", "status bit12", 32'(rdata[12]), 32'(m_sts));
    chk("R6", "enable bit13", 32'(rdata[13]), 32'(m_en));
    chk("R7", "irq enable bit14", 32'(rdata[14]), 32'(m_ie));
    chk("R8", "word", rdata, exp_rdata());
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input bit b, input bit r, input bit w, input logic [31:0] d, input bit di);
    busy = b; rdy = r; we = w; wd = d; dirq = di;
    @(posedge clk);
    model_edge(b, r, w, d, di);
    cyc++;
    @(negedge clk);
    if (force_done) begin
      pulses++;
      if (first_pulse < 0) first_pulse = cyc;
    end
    compare_all();
  endtask

  localparam logic [31:0] W_EN    = 32'h0000_2000;
  localparam logic [31:0] W_EN_IE = 32'h0000_6000;
  localparam logic [31:0] W_CLR   = 32'h0000_1000;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int start;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R6: reset values
    chk("R6", "reset word", rdata, 32'h0);
    chk("R6", "reset force", 32'(force_done), 0);
    chk("R7", "reset irq", 32'(irq), 0);

    // R6: disabled -> long stall does nothing
    pulses = 0;
    for (int i = 0; i < 3*T; i++) step(1, 0, 0, '0, 0);
    chk("R6", "pulses while disabled", pulses, 0);

    // enable, then near-miss stalls (R2)
    step(0, 1, 1, W_EN, 0);
    pulses = 0;
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < T-1; i++) step(1, 0, 0, '0, 0);
      step(1, 1, 0, '0, 0);
    end
    chk("R2", "pulses for short stalls", pulses, 0);

    // long stall: one pulse at edge T (R1, R3)
    pulses = 0; first_pulse = -1; start = cyc;
    for (int i = 0; i < 3*T; i++) step(1, 0, 0, '0, 0);
    chk("R1", "pulse edge offset", first_pulse - start, T);
    chk("R3", "pulses in one long stall", pulses, 1);
    chk("R4", "data_bad held in stall", 32'(bad), 1);
    step(0, 1, 0, '0, 0);
    chk("R4", "data_bad after access end", 32'(bad), 0);

    // R5: writing 0 keeps status; R7 irq
    step(0, 1, 1, W_EN, 0);
    chk("R5", "status after write-0", 32'(rdata[12]), 1);
    step(0, 1, 1, W_EN_IE, 0);
    chk("R7", "irq with status and enable", 32'(irq), 1);
    step(0, 1, 1, W_EN_IE | W_CLR, 0);
    chk("R5", "status after W1C", 32'(rdata[12]), 0);
    chk("R7", "irq after clear", 32'(irq), 0);

    // R5: timeout coincident with clear write; status kept
    step(0, 1, 1, W_EN_IE, 0);
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < T-1; i++) step(1, 0, 0, '0, 0);
      step(1, 0, 1, W_EN_IE | W_CLR, 0);
      chk("R5", "status with coincident clear", 32'(rdata[12]), 1);
      step(0, 1, 0, '0, 0);
    end

    // R8: device interrupt mirror
    step(0, 1, 0, '0, 1);
    chk("R8", "bit11 high", 32'(rdata[11]), 1);
    step(0, 1, 0, '0, 0);
    chk("R8", "bit11 low", 32'(rdata[11]), 0);

    // random phase
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      bit b, r, w;
      logic [31:0] d;
      b = ($urandom % 8) != 0;
      r = ($urandom % 24) == 0;
      w = ($urandom % 30) == 0;
      d = $urandom;
      if (($urandom % 10) != 0) d[13] = 1'b1;
      step(b, r, w, d, $urandom % 2);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule